// File: doc/BRIEF.md
# Serial Configuration Stream Checker

This block watches a serial configuration bitstream, one bit per strobed cycle, and checks that its framing is sound. It expects a header first. The header is a fill byte of all ones, a 4-bit preamble code, a 24-bit length count and a 4-bit pad of ones. After the header it expects a fixed number of data frames. Each frame opens with a zero start bit and closes with a 4-bit check field. A one-byte postamble ends the stream.

The checker captures the length count and counts frames as they complete, pulsing a strobe for each one. It reports the first framing fault as a sticky flag with a code that says which field was wrong, and then ignores all further input until reset. A stream-complete flag rises only when every expected frame and a correct postamble have been seen. The frame length and the frame count are parameters, so one checker serves every device size. Frame payload is only counted. It is not stored or checked.

Top module: `cfg_stream_checker`

## Requirements
- R1: The first 8 accepted bits must all be 1. Any other value sets `frame_err` with `err_code` = 1.
- R2: The next 4 bits, in serial order, must be 0,0,1,0. Any other value sets `err_code` = 2.
- R3: The next 24 bits are the length count, first bit most significant. After its last bit it appears on `length_count` and holds until reset. `length_count` is 0 before that.
- R4: The 4 bits after the length count must all be 1. Any other value sets `err_code` = 3.
- R5: Every frame is FRAME_BITS long, and its first bit must be 0. A 1 there sets `err_code` = 4 on that bit.
- R6: With CONST_CHECK = 1, the last 4 bits of a frame, in serial order, must be 0,1,1,0. Any other value sets `err_code` = 5.
- R7: A frame that ends correctly pulses `frame_done` high for exactly one cycle, in the cycle after its last bit is accepted. In that same cycle `frame_count` is one higher.
- R8: After NUM_FRAMES frames, the next 8 bits must be 0,1,1,1,1,1,1,1. If they are, `stream_done` rises the cycle after the last of them. Any other value sets `err_code` = 6.
- R9: A cycle with `bit_valid` low changes no state and produces no `frame_done`.
- R10: A framing error is sticky. `frame_err` and `err_code` hold, and later bits change neither `frame_count` nor `length_count` nor `stream_done`.
- R11: Once `stream_done` is high, later bits are ignored: no further `frame_done` and no change of count or length.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial stream bit |
| length_count | output | 24 | Captured length count |
| frame_count | output | $clog2(NUM_FRAMES+1) | Frames completed so far |
| frame_done | output | 1 | One-cycle pulse per good frame |
| frame_err | output | 1 | Sticky framing error |
| err_code | output | 3 | Field that failed (1 to 6), 0 when no error |
| stream_done | output | 1 | Full stream with postamble checked |

## Verification
The bench builds the checker with FRAME_BITS = 10 and NUM_FRAMES = 3. Each frame is then a start bit, five payload bits and the check nibble, and a complete stream is under a hundred bits. These small values let the bench run the full path from header to postamble many times, with an error placed in each field in turn. They also let it test the frame before the last, the last frame, and the switch from frames to postamble. Idle gaps are mixed into the bit strobe so that hold behaviour is exercised in every state.

// File: rtl/cfg_stream_checker.sv
module cfg_stream_checker #(
  parameter int FRAME_BITS  = 226,
  parameter int NUM_FRAMES  = 788,
  parameter bit CONST_CHECK = 1'b1,
  localparam int FCW = $clog2(NUM_FRAMES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_valid,
  input  logic           bit_in,
  output logic [23:0]    length_count,
  output logic [FCW-1:0] frame_count,
  output logic           frame_done,
  output logic           frame_err,
  output logic [2:0]     err_code,
  output logic           stream_done
);
  localparam int MAXB = (FRAME_BITS > 24) ? FRAME_BITS : 24;
  localparam int BW = $clog2(MAXB + 1);
  localparam logic [BW-1:0]  F_LAST = BW'(FRAME_BITS - 1);
  localparam logic [FCW-1:0] N_LAST = FCW'(NUM_FRAMES - 1);

  typedef enum logic [2:0] {S_FILL, S_PRE, S_LEN, S_PAD, S_FRM, S_POST, S_DONE, S_HALT} st_t;

  st_t         st;
  logic [BW-1:0] bcnt;
  logic [23:0] sh;
  logic [23:0] nxt;
  logic        take;

  assign nxt  = {sh[22:0], bit_in};
  assign take = bit_valid && (st != S_DONE) && (st != S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_FILL;
      bcnt         <= '0;
      sh           <= '0;
      length_count <= '0;
      frame_count  <= '0;
      frame_done   <= 1'b0;
      frame_err    <= 1'b0;
      err_code     <= 3'd0;
      stream_done  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (take) begin
        sh   <= nxt;
        bcnt <= bcnt + 1'b1;
        case (st)
          S_FILL: if (bcnt == BW'(7)) begin
            bcnt <= '0;
            if (nxt[7:0] == 8'hFF) st <= S_PRE;
            else begin st <= S_HALT; frame_err <= 1'b1; err_code <= 3'd1; end
          end
          S_PRE: if (bcnt == BW'(3)) begin
            bcnt <= '0;
            if (nxt[3:0] == 4'b0010) st <= S_LEN;
            else begin st <= S_HALT; frame_err <= 1'b1; err_code <= 3'd2; end
          end
          S_LEN: if (bcnt == BW'(23)) begin
            bcnt         <= '0;
            length_count <= nxt;
            st           <= S_PAD;
          end
          S_PAD: if (bcnt == BW'(3)) begin
            bcnt <= '0;
            if (nxt[3:0] == 4'hF) st <= S_FRM;
            else begin st <= S_HALT; frame_err <= 1'b1; err_code <= 3'd3; end
          end
          S_FRM: begin
            if (bcnt == '0 && bit_in) begin
              st <= S_HALT; frame_err <= 1'b1; err_code <= 3'd4;
            end else if (bcnt == F_LAST) begin
              bcnt <= '0;
              if (CONST_CHECK && nxt[3:0] != 4'b0110) begin
                st <= S_HALT; frame_err <= 1'b1; err_code <= 3'd5;
              end else begin
                frame_done  <= 1'b1;
                frame_count <= frame_count + 1'b1;
                if (frame_count == N_LAST) st <= S_POST;
              end
            end
          end
          S_POST: if (bcnt == BW'(7)) begin
            bcnt <= '0;
            if (nxt[7:0] == 8'h7F) begin st <= S_DONE; stream_done <= 1'b1; end
            else begin st <= S_HALT; frame_err <= 1'b1; err_code <= 3'd6; end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_stream_checker_sva.sv
module cfg_stream_checker_sva #(
  parameter int NUM_FRAMES = 788,
  parameter int FCW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_valid,
  input logic [23:0]    length_count,
  input logic [FCW-1:0] frame_count,
  input logic           frame_done,
  input logic           frame_err,
  input logic [2:0]     err_code,
  input logic           stream_done
);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err && $stable(err_code) && $stable(frame_count) && !stream_done);
  assert_err_coded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> err_code != 3'd0);
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |=> stream_done && $stable(frame_count) && $stable(length_count) && !frame_done);
  assert_done_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |-> (int'(frame_count) == NUM_FRAMES) && !frame_err);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_pulse_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_count != $past(frame_count));
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> !frame_done && $stable(frame_count) && $stable(length_count));
endmodule

bind cfg_stream_checker cfg_stream_checker_sva #(.NUM_FRAMES(NUM_FRAMES), .FCW(FCW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .length_count(length_count),
  .frame_count(frame_count), .frame_done(frame_done), .frame_err(frame_err),
  .err_code(err_code), .stream_done(stream_done)
);

// File: tb/cfg_stream_checker_bench.sv
`timescale 1ns/1ps
module cfg_stream_checker_bench;
  localparam int FB = 10;
  localparam int NF = 3;
  localparam int FCW = $clog2(NF + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic [23:0] length_count;
  logic [FCW-1:0] frame_count;
  logic frame_done, frame_err, stream_done;
  logic [2:0] err_code;

  int n_cmp = 0, n_bad = 0, nsent = 0;
  bit gaps = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  cfg_stream_checker #(.FRAME_BITS(FB), .NUM_FRAMES(NF), .CONST_CHECK(1'b1)) u_cfg_stream_checker (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .length_count(length_count), .frame_count(frame_count), .frame_done(frame_done),
    .frame_err(frame_err), .err_code(err_code), .stream_done(stream_done));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && frame_done) begin
      if (exp_q.size() == 0) chk("R7 unexpected frame_done", 32'd1, 32'd0);
      else chk("R7 frame_count at pulse", 32'(frame_count), 32'(exp_q.pop_front()));
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; nsent = 0;
    exp_q.delete();
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_in = b; nsent++;
    if (gaps && (nsent % 5 == 0)) begin
      @(negedge clk); bit_valid = 1'b0; bit_in = ~b;
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); bit_valid = 1'b0; end
  endtask

  task automatic send_frame(input logic st, input logic [3:0] ck, input int num);
    send_bit(st);
    for (int i = 0; i < FB - 5; i++) send_bit(logic'((num + i) % 2));
    send_bits({28'd0, ck}, 4);
  endtask

  task automatic header(input logic [7:0] fill, input logic [3:0] pre, input logic [23:0] len, input logic [3:0] pad);
    send_bits({24'd0, fill}, 8);
    send_bits({28'd0, pre}, 4);
    send_bits({8'd0, len}, 24);
    send_bits({28'd0, pad}, 4);
  endtask

  task automatic finish_check(input string req, input logic err, input logic [2:0] code,
                              input int fc, input logic [23:0] len, input logic done);
    idle(3);
    chk({req, " frame_err"}, 32'(frame_err), 32'(err));
    chk({req, " err_code"}, 32'(err_code), 32'(code));
    chk({req, " frame_count"}, 32'(frame_count), 32'(fc));
    chk({req, " length_count"}, 32'(length_count), 32'(len));
    chk({req, " stream_done"}, 32'(stream_done), 32'(done));
    chk({req, " pending frames"}, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    chk("R12 length_count", 32'(length_count), 32'd0);
    chk("R12 frame_count", 32'(frame_count), 32'd0);
    chk("R12 flags", {29'd0, frame_done, frame_err, stream_done}, 32'd0);
    chk("R12 err_code", 32'(err_code), 32'd0);

    // R3 R5 R6 R7 R8 R9: good stream with gaps
    gaps = 1'b1;
    header(8'hFF, 4'b0010, 24'hA5C3F1, 4'hF);
    idle(2);
    chk("R3 length captured", 32'(length_count), 32'h00A5C3F1);
    for (int f = 0; f < NF; f++) begin
      send_frame(1'b0, 4'b0110, f);
      exp_q.push_back(f + 1);
      idle(4);
      chk("R9 count holds while idle", 32'(frame_count), 32'(f + 1));
      chk("R9 no pulse while idle", 32'(frame_done), 32'd0);
    end
    chk("R8 not done before postamble", 32'(stream_done), 32'd0);
    send_bits(32'h7F, 8);
    @(negedge clk); bit_valid = 1'b0;
    chk("R8 done one cycle after postamble", 32'(stream_done), 32'd1);
    // R11 extra bits ignored
    send_frame(1'b0, 4'b0110, 0);
    send_frame(1'b1, 4'b0000, 0);
    finish_check("R11", 1'b0, 3'd0, NF, 24'hA5C3F1, 1'b1);

    // R1 bad fill
    gaps = 1'b0;
    do_reset();
    header(8'hEF, 4'b0010, 24'h123456, 4'hF);
    finish_check("R1", 1'b1, 3'd1, 0, 24'h0, 1'b0);

    // R2 bad preamble, then R10 later bits ignored
    do_reset();
    header(8'hFF, 4'b0011, 24'h123456, 4'hF);
    send_frame(1'b0, 4'b0110, 1);
    finish_check("R2 R10", 1'b1, 3'd2, 0, 24'h0, 1'b0);

    // R4 bad pad
    do_reset();
    header(8'hFF, 4'b0010, 24'h00FF00, 4'hD);
    send_frame(1'b0, 4'b0110, 1);
    finish_check("R4", 1'b1, 3'd3, 0, 24'h00FF00, 1'b0);

    // R5 bad start bit in second frame
    do_reset();
    gaps = 1'b1;
    header(8'hFF, 4'b0010, 24'h800001, 4'hF);
    send_frame(1'b0, 4'b0110, 0); exp_q.push_back(1);
    send_frame(1'b1, 4'b0110, 1);
    send_frame(1'b0, 4'b0110, 2);
    send_bits(32'h7F, 8);
    finish_check("R5 R10", 1'b1, 3'd4, 1, 24'h800001, 1'b0);

    // R6 bad check nibble in first frame
    do_reset();
    gaps = 1'b0;
    header(8'hFF, 4'b0010, 24'h000002, 4'hF);
    send_frame(1'b0, 4'b0100, 0);
    send_frame(1'b0, 4'b0110, 1);
    finish_check("R6", 1'b1, 3'd5, 0, 24'h000002, 1'b0);

    // R6 bad check nibble in last frame
    do_reset();
    header(8'hFF, 4'b0010, 24'hFFFFFF, 4'hF);
    for (int f = 0; f < NF - 1; f++) begin
      send_frame(1'b0, 4'b0110, f); exp_q.push_back(f + 1);
    end
    send_frame(1'b0, 4'b1110, 2);
    send_bits(32'h7F, 8);
    finish_check("R6 last", 1'b1, 3'd5, NF - 1, 24'hFFFFFF, 1'b0);

    // R8 bad postamble
    do_reset();
    header(8'hFF, 4'b0010, 24'h5A5A5A, 4'hF);
    for (int f = 0; f < NF; f++) begin
      send_frame(1'b0, 4'b0110, f); exp_q.push_back(f + 1);
    end
    send_bits(32'hFF, 8);
    finish_check("R8 bad postamble", 1'b1, 3'd6, NF, 24'h5A5A5A, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule